// File: doc/BRIEF.md
# Three-Wire Serial Clock-Chip Master

This block runs transactions on a three-wire serial link to a real-time clock chip. The three lines are a chip-enable strobe, a serial clock and one shared data line. The data line leaves the block as three signals: a driven value, an output enable and a sampled input. A transaction is requested with one command byte and one write-data byte. Bit 0 of the command byte sets the direction. Every transaction uses one chip-enable window and sixteen serial clock pulses.

A write sends the command byte and then the data byte, least significant bit first. A read sends the command byte, then releases the data line and collects eight response bits, filling the result from its least significant bit upward. On that link the clock chip decodes these command values: seconds 0x80/0x81, minutes 0x82/0x83, hours 0x84/0x85, date 0x86/0x87, month 0x88/0x89, day of week 0x8A, year 0x8C/0x8D. Writing 0xA5 to 0x90 sets up the clock chip's backup-supply charger.

The length of each serial clock phase is a parameter, counted in system clock cycles. It is chosen so that the clock chip's setup and hold times are met. A busy flag stays high until the single-cycle done pulse.

Top module: `serial_rtc_master`

## Requirements
- R1: Whenever chip enable is low, the serial clock is low, the data value is 0 and the data line is driven (output enable 1). After reset, busy, done and the read result are all 0.
- R2: Chip enable rises HALF_CYC cycles before the bit-0 low phase begins, so it is high for exactly 2*HALF_CYC cycles before the first rising serial clock. The serial clock is never high while chip enable is low.
- R3: The transmitted bits are sent least significant bit first. In a write, the sixteen bits sampled at the rising serial clock edges are the command byte followed by the data byte.
- R4: Each bit is placed on the data line during the low phase. The data value and the output enable do not change while the serial clock is high.
- R5: Every chip-enable window holds exactly 16 rising serial clock edges. Bit 0 of the command selects the direction: 1 means read (8 command bits, then 8 sampled bits), 0 means write.
- R6: On a read, output enable is 0 from the falling edge that ends the 8th command bit until chip enable drops, which is 17*HALF_CYC cycles. On a write it stays 1 throughout.
- R7: On a read, the data line is sampled in the last cycle of each low phase before rising edges 9 to 16. The first sample lands in bit 0 of the result. The result holds until the next read, and writes leave it unchanged.
- R8: Busy goes high in the cycle after an accepted request and stays high through the done cycle. A request presented while busy is ignored: it does not alter the transfer and does not start a new one.
- R9: Done is high for exactly one cycle, 34*HALF_CYC cycles after the accepting edge. At the same edge, chip enable, the serial clock and the data value are all low.
- R10: Each serial clock high phase and each low phase lasts exactly HALF_CYC system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when not busy |
| req_cmd | input | BYTE_W | Command byte; bit 0 = 1 selects read |
| req_wdata | input | BYTE_W | Byte sent after the command on a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Single-cycle completion pulse |
| rd_data | output | BYTE_W | Byte collected by the last read |
| rtc_ce | output | 1 | Chip enable to the clock chip |
| rtc_sclk | output | 1 | Serial clock |
| rtc_sio_o | output | 1 | Value driven on the data line |
| rtc_sio_oe | output | 1 | Data line output enable |
| rtc_sio_i | input | 1 | Value sampled from the data line |

## Verification
Directed commands 0x55/0xAA paired with response bytes 0xAA/0x55 tell least-significant-first order apart from most-significant-first order, and reveal a one-bit shift error. All-zero and all-one responses expose a stuck or missing sample. Alternating reads and writes show whether the release window covers only reads, and whether a write leaves the stored result untouched. Random commands and data from a fixed seed, some carrying an extra request while busy, cover the remaining bit patterns and show that a mid-transfer request neither changes the transfer nor starts another.

// File: rtl/rtc3w_pkg.sv
`timescale 1ns/1ps
package rtc3w_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_DONE
  } rtc3w_state_e;

  // Direction bit of a command: 1 = read
  function automatic logic cmd_is_read(input logic cmd_lsb);
    return cmd_lsb;
  endfunction

  // Cycles from accepting edge to the done cycle: lead + 2 per bit + tail
  function automatic int unsigned xfer_len(input int unsigned half_cyc,
                                           input int unsigned frame_bits);
    return (2 * frame_bits + 2) * half_cyc;
  endfunction

  // Data line is released once the command part of a read has gone out
  function automatic logic line_released(input logic rd,
                                         input int unsigned idx,
                                         input int unsigned cmd_bits);
    return rd && (idx >= cmd_bits);
  endfunction

endpackage

// File: rtl/rtc3w_halfcnt.sv
`timescale 1ns/1ps
module rtc3w_halfcnt #(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc3w_txshift.sv
`timescale 1ns/1ps
module rtc3w_txshift #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [BYTE_W-1:0] cmd,
  input  logic [BYTE_W-1:0] wdata,
  output logic              bit_out
);
  localparam int unsigned SW = 2 * BYTE_W;

  logic [SW-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= {wdata, cmd};
    else if (shift) sr <= {1'b0, sr[SW-1:1]};
  end

  assign bit_out = sr[0];
endmodule

// File: rtl/rtc3w_rxshift.sv
`timescale 1ns/1ps
module rtc3w_rxshift #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              din,
  output logic [BYTE_W-1:0] byte_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      byte_q <= '0;
    else if (sample) byte_q <= {din, byte_q[BYTE_W-1:1]};
  end
endmodule

// File: rtl/serial_rtc_master.sv
`timescale 1ns/1ps
module serial_rtc_master
  import rtc3w_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned HALF_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BYTE_W-1:0] req_cmd,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rtc_ce,
  output logic              rtc_sclk,
  output logic              rtc_sio_o,
  output logic              rtc_sio_oe,
  input  logic              rtc_sio_i
);
  localparam int unsigned CMD_BITS = BYTE_W;
  localparam int unsigned NBITS    = 2 * BYTE_W;
  localparam int unsigned IW       = $clog2(NBITS);

  rtc3w_state_e  state;
  logic [IW-1:0] bit_idx;
  logic          rd_q;

  // named internal events
  logic accept, tick, run, bit_last, shift_ev, sample_ev, released, tx_bit;

  assign accept   = req_valid && (state == ST_IDLE);
  assign run      = (state != ST_IDLE) && (state != ST_DONE);
  assign bit_last = (bit_idx == IW'(NBITS - 1));
  assign shift_ev = (state == ST_HIGH) && tick;
  assign released = line_released(rd_q, 32'(bit_idx), CMD_BITS) &&
                    ((state == ST_LOW) || (state == ST_HIGH) || (state == ST_TAIL));
  assign sample_ev = (state == ST_LOW) && tick &&
                     line_released(rd_q, 32'(bit_idx), CMD_BITS);

  rtc3w_halfcnt #(.HALF_CYC(HALF_CYC)) u_half (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  rtc3w_txshift #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept), .shift(shift_ev),
    .cmd(req_cmd), .wdata(req_wdata), .bit_out(tx_bit)
  );

  rtc3w_rxshift #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample(sample_ev), .din(rtc_sio_i), .byte_q(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_idx <= '0;
      rd_q    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          state   <= ST_LEAD;
          bit_idx <= '0;
          rd_q    <= cmd_is_read(req_cmd[0]);
        end
        ST_LEAD: if (tick) state <= ST_LOW;
        ST_LOW:  if (tick) state <= ST_HIGH;
        ST_HIGH: if (tick) begin
          if (bit_last) state <= ST_TAIL;
          else begin
            state   <= ST_LOW;
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_TAIL: if (tick) state <= ST_DONE;
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);
  assign rtc_ce     = run;
  assign rtc_sclk   = (state == ST_HIGH);
  assign rtc_sio_oe = !released;
  assign rtc_sio_o  = ((state == ST_LOW) || (state == ST_HIGH)) && !released && tx_bit;

  // ---------------- assertions ----------------
  logic        sclk_q;
  int unsigned hi_len, pulse_cnt, since_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      hi_len    <= 0;
      pulse_cnt <= 0;
      since_acc <= 0;
    end else begin
      sclk_q    <= rtc_sclk;
      hi_len    <= rtc_sclk ? hi_len + 1 : 0;
      if (!rtc_ce)                  pulse_cnt <= 0;
      else if (rtc_sclk && !sclk_q) pulse_cnt <= pulse_cnt + 1;
      if (accept)    since_acc <= 0;
      else if (busy) since_acc <= since_acc + 1;
    end
  end

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rtc_ce |-> (!rtc_sclk && !rtc_sio_o && rtc_sio_oe));

  assert_clk_inside_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rtc_ce) |-> !rtc_sclk);

  assert_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_sclk && $past(rtc_sclk)) |-> ($stable(rtc_sio_o) && $stable(rtc_sio_oe)));

  assert_pulse_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rtc_ce) |-> (pulse_cnt == NBITS));

  assert_dir_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_q));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_done_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since_acc == xfer_len(HALF_CYC, NBITS)));

  assert_high_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rtc_sclk) |-> (hi_len == HALF_CYC));

endmodule

// File: tb/sim_serial_rtc_master.sv
`timescale 1ns/1ps
module sim_serial_rtc_master;
  localparam int H  = 3;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [BW-1:0] req_cmd = '0, req_wdata = '0;
  logic busy, done, rtc_ce, rtc_sclk, rtc_sio_o, rtc_sio_oe, rtc_sio_i;
  logic [BW-1:0] rd_data;

  always #4 clk = ~clk;

  serial_rtc_master #(.BYTE_W(BW), .HALF_CYC(H)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .rtc_ce(rtc_ce), .rtc_sclk(rtc_sclk), .rtc_sio_o(rtc_sio_o),
    .rtc_sio_oe(rtc_sio_oe), .rtc_sio_i(rtc_sio_i)
  );

  int tests = 0, fails = 0, cyc = 0;

  // slave-side monitor state
  int rise_cnt = 0, lead_len = 0, ce_cnt = 0, rel_cnt = 0;
  int hi_run = 0, hi_bad = 0, lo_run = 0, lo_bad = 0, stab_bad = 0, idle_bad = 0;
  logic cap [32];
  logic oe_cap [32];
  logic sclk_p = 1'b0, sio_p = 1'b0, oe_p = 1'b1;
  logic [BW-1:0] resp = '0;

  assign rtc_sio_i = (rise_cnt >= 8 && rise_cnt < 16) ? resp[rise_cnt - 8] : 1'b0;

  function automatic int exp_len(input int h);
    return 2 * h * (16 + 1);
  endfunction
  function automatic int exp_release(input int h);
    return h * (2 * 8 + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rtc_ce && !sclk_p && rtc_sclk) begin
        if (rise_cnt < 32) begin
          cap[rise_cnt] = rtc_sio_o;
          oe_cap[rise_cnt] = rtc_sio_oe;
        end
        if (rise_cnt == 0) lead_len = ce_cnt;
        rise_cnt++;
      end
      if (rtc_sclk) hi_run++;
      else if (sclk_p) begin
        if (hi_run != H) hi_bad++;
        hi_run = 0;
      end
      if (rtc_ce && !rtc_sclk && rise_cnt > 0 && rise_cnt < 16) lo_run++;
      if (rtc_sclk && !sclk_p && rise_cnt > 1) begin
        if (lo_run != H) lo_bad++;
        lo_run = 0;
      end else if (rtc_sclk && !sclk_p) lo_run = 0;
      if (rtc_sclk && sclk_p && (rtc_sio_o != sio_p || rtc_sio_oe != oe_p)) stab_bad++;
      if (rtc_ce) ce_cnt++;
      if (rtc_ce && !rtc_sio_oe) rel_cnt++;
      if (!rtc_ce && (rtc_sclk || rtc_sio_o || !rtc_sio_oe)) idle_bad++;
      sclk_p = rtc_sclk; sio_p = rtc_sio_o; oe_p = rtc_sio_oe;
    end
  end

  logic [BW-1:0] exp_rd = '0;

  task automatic do_txn(input logic [BW-1:0] cmd, input logic [BW-1:0] wd,
                        input logic [BW-1:0] rsp, input bit intrude);
    int n;
    bit rd;
    logic [BW-1:0] got_c, got_d;
    rd = cmd[0];
    @(posedge clk); #1;
    rise_cnt = 0; lead_len = 0; ce_cnt = 0; rel_cnt = 0;
    hi_bad = 0; lo_bad = 0; lo_run = 0; stab_bad = 0; idle_bad = 0;
    resp = rsp;
    req_cmd = cmd; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    n = 0;
    forever begin
      @(negedge clk);
      if (done || n > 4 * exp_len(H)) break;
      if (n == 1) chk(busy === 1'b1, "R8", "busy after accept", busy, 1);
      if (intrude && n == 5) begin req_valid = 1'b1; req_cmd = ~cmd; req_wdata = ~wd; end
      if (intrude && n == 8) begin req_valid = 1'b0; req_cmd = cmd; end
      n++;
    end
    chk(n == exp_len(H), "R9", "done latency", n, exp_len(H));
    chk(!rtc_ce && !rtc_sclk && !rtc_sio_o, "R9", "lines low at done",
        {rtc_ce, rtc_sclk, rtc_sio_o}, 0);
    @(negedge clk);
    chk(!done && !busy, "R9", "done single cycle", {done, busy}, 0);
    repeat (3) @(negedge clk);
    chk(!rtc_ce && !busy, "R8", "no extra start", {rtc_ce, busy}, 0);
    chk(rise_cnt == 16, "R5", "rising edges in window", rise_cnt, 16);
    chk(lead_len == 2 * H, "R2", "ce lead cycles", lead_len, 2 * H);
    for (int i = 0; i < 8; i++) begin
      got_c[i] = cap[i];
      got_d[i] = cap[8 + i];
    end
    chk(got_c == cmd, "R3", "command bits lsb first", got_c, cmd);
    if (!rd) chk(got_d == wd, "R3", "write data bits lsb first", got_d, wd);
    chk(stab_bad == 0, "R4", "data moved while clock high", stab_bad, 0);
    chk(hi_bad == 0 && lo_bad == 0, "R10", "phase lengths", hi_bad + lo_bad, 0);
    chk(idle_bad == 0, "R1", "lines outside window", idle_bad, 0);
    chk(rel_cnt == (rd ? exp_release(H) : 0), "R6", "released cycles",
        rel_cnt, rd ? exp_release(H) : 0);
    if (rd) begin
      chk(oe_cap[7] === 1'b1 && oe_cap[8] === 1'b0, "R6", "release at command end",
          {oe_cap[7], oe_cap[8]}, 2);
      exp_rd = rsp;
    end
    chk(rd_data == exp_rd, "R7", rd ? "read result" : "result kept on write",
        rd_data, exp_rd);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!rtc_ce && !rtc_sclk && !rtc_sio_o && rtc_sio_oe && !busy && !done && rd_data == 0,
        "R1", "reset state", {rtc_ce, rtc_sclk, rtc_sio_o, rtc_sio_oe, busy, done}, 4);
    rst_n = 1'b1;
    // directed corner cases
    do_txn(8'h90, 8'hA5, 8'h00, 1'b0);  // charger setup write (R3)
    do_txn(8'h81, 8'h00, 8'h59, 1'b0);  // seconds read (R7)
    do_txn(8'h8C, 8'h24, 8'hFF, 1'b1);  // write while extra request arrives (R8)
    do_txn(8'h8D, 8'h00, 8'h00, 1'b0);  // all-zero response
    do_txn(8'h8D, 8'h00, 8'hFF, 1'b1);  // all-one response, intrusion on read
    do_txn(8'h55, 8'hAA, 8'hAA, 1'b0);  // read with alternating pattern
    do_txn(8'hAA, 8'h55, 8'h55, 1'b0);  // write keeps previous result
    // random mix
    for (int k = 0; k < 16; k++) begin
      logic [BW-1:0] c, w, r;
      c = BW'($urandom); w = BW'($urandom); r = BW'($urandom);
      do_txn(c, w, r, k[1]);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule